// File: doc/BRIEF.md
# Carry-Chained Add/Subtract Unit

This block performs one of six integer add or subtract operations on two operands of parameterised width (32 bits by default) and registers the result. Besides plain add and subtract, it offers a reversed subtract that takes the first operand away from the second, and carry-chained forms of all three, which use an externally supplied carry flag so that wide numbers can be processed one word at a time.

Carry follows the not-borrow convention: every subtraction is formed as an addition of the inverted subtrahend, so a carry of 1 means no borrow happened, and a clear carry in a subtract-with-carry form removes one extra from the result. When the flag-update input is set, the negative, zero, carry and overflow flags of the operation are captured in a flag register; otherwise that register holds. The caller feeds the registered carry flag back as the carry input of the next word to chain multiword arithmetic.

Top module: `addsub_carry_unit`

## Requirements
- R1: Opcode 0 (add) yields opa + opb modulo 2^WIDTH on `result` one clock after the inputs are presented.
- R2: Opcode 1 (subtract) yields opa - opb and opcode 2 (reverse subtract) yields opb - opa, both modulo 2^WIDTH.
- R3: Opcode 3 (add with carry) yields opa + opb + carry_in modulo 2^WIDTH.
- R4: Opcode 4 (subtract with carry) yields opa - opb - (1 - carry_in) and opcode 5 (reverse subtract with carry) yields opb - opa - (1 - carry_in), both modulo 2^WIDTH.
- R5: On a flag update, `flag_n` takes the result's top bit and `flag_z` is 1 exactly when the result is all zeros.
- R6: On a flag update, `flag_c` is the carry out of the add forms; for the subtract forms it is 1 when no borrow occurs (minuend not less than subtrahend plus the borrow-in).
- R7: On a flag update, `flag_v` is 1 when the exact two's-complement result lies outside the signed range of WIDTH bits.
- R8: When `flag_en` is 0, all four flags keep their previous values while `result` still updates.
- R9: Opcodes 6 and 7 give a zero `result` and leave all four flags unchanged, whatever `flag_en` is.
- R10: A synchronous active-high `rst` clears `result` and all four flags on the next rising edge.
- R11: Feeding `flag_c` back into `carry_in` lets an add or subtract span two words: the low word uses opcode 0 or 1, the high word opcode 3 or 4, and the concatenated results equal the double-width sum or difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Operation code (0..5 valid, 6 and 7 reserved) |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| carry_in | input | 1 | Current carry flag for the chained forms |
| flag_en | input | 1 | Capture condition flags from this operation |
| result | output | WIDTH | Registered operation result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / not-borrow flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The awkward corners are the borrow boundaries of the chained subtracts, where a clear carry pushes an equal-operand subtraction below zero and flips both carry and zero, and signed overflow at the edges of the range. A 4-bit instance makes them reachable without search: the bench sweeps every opcode, both carry values and every operand pair, alternating the flag-update input so that holding and capturing are both exercised against a running flag model computed from integer arithmetic. A two-word chain with the carry flag routed back confirms the multiword use.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_RSB = 3'd2,
    OP_ADC = 3'd3,
    OP_SBC = 3'd4,
    OP_RSC = 3'd5
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

endpackage

// File: rtl/addsub_operand_steer.sv
module addsub_operand_steer
  import addsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             carry_in,
  output logic [WIDTH-1:0] add_x,
  output logic [WIDTH-1:0] add_y,
  output logic             add_cin,
  output logic             op_valid
);

  // Subtractions become x + ~y + cin; the reversed forms swap which
  // operand is inverted.
  always_comb begin
    add_x    = '0;
    add_y    = '0;
    add_cin  = 1'b0;
    op_valid = 1'b1;
    case (op)
      OP_ADD: begin add_x = opa; add_y = opb;  add_cin = 1'b0;     end
      OP_SUB: begin add_x = opa; add_y = ~opb; add_cin = 1'b1;     end
      OP_RSB: begin add_x = opb; add_y = ~opa; add_cin = 1'b1;     end
      OP_ADC: begin add_x = opa; add_y = opb;  add_cin = carry_in; end
      OP_SBC: begin add_x = opa; add_y = ~opb; add_cin = carry_in; end
      OP_RSC: begin add_x = opb; add_y = ~opa; add_cin = carry_in; end
      default: op_valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/addsub_adder.sv
module addsub_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] add_x,
  input  logic [WIDTH-1:0] add_y,
  input  logic             add_cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] wide;

  always_comb begin
    wide = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, add_cin};
    sum  = wide[MSB:0];
    cout = wide[WIDTH];
    ovf  = (add_x[MSB] == add_y[MSB]) && (wide[MSB] != add_x[MSB]);
  end

endmodule

// File: rtl/addsub_flag_reg.sv
module addsub_flag_reg
  import addsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [WIDTH-1:0] sum,
  input  logic             cout,
  input  logic             ovf,
  output nzcv_t            flags
);

  localparam int MSB = WIDTH - 1;

  nzcv_t next_flags;

  always_comb begin
    next_flags.n = sum[MSB];
    next_flags.z = (sum == '0);
    next_flags.c = cout;
    next_flags.v = ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else if (capture) begin
      flags <= next_flags;
    end
  end

  // R8: without a capture the register must hold
  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(flags));

endmodule

// File: rtl/addsub_carry_unit.sv
module addsub_carry_unit
  import addsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             carry_in,
  input  logic             flag_en,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] add_x;
  logic [WIDTH-1:0] add_y;
  logic             add_cin;
  logic             op_valid;
  logic [WIDTH-1:0] sum;
  logic             cout;
  logic             ovf;
  nzcv_t            flags;

  addsub_operand_steer #(.WIDTH(WIDTH)) u_steer (
    .op       (op),
    .opa      (opa),
    .opb      (opb),
    .carry_in (carry_in),
    .add_x    (add_x),
    .add_y    (add_y),
    .add_cin  (add_cin),
    .op_valid (op_valid)
  );

  addsub_adder #(.WIDTH(WIDTH)) u_adder (
    .add_x   (add_x),
    .add_y   (add_y),
    .add_cin (add_cin),
    .sum     (sum),
    .cout    (cout),
    .ovf     (ovf)
  );

  addsub_flag_reg #(.WIDTH(WIDTH)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .capture (flag_en && op_valid),
    .sum     (sum),
    .cout    (cout),
    .ovf     (ovf),
    .flags   (flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
    end else begin
      result <= op_valid ? sum : '0;
    end
  end

  assign flag_n = flags.n;
  assign flag_z = flags.z;
  assign flag_c = flags.c;
  assign flag_v = flags.v;

  // R9: reserved codes give zero and leave flags alone
  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (op > 3'd5) |=> (result == '0) && $stable({flag_n, flag_z, flag_c, flag_v}));

  // R5: captured N and Z agree with the registered result
  assert_nz_match_R5: assert property (@(posedge clk) disable iff (rst)
    (flag_en && op <= 3'd5) |=> (flag_n == result[MSB]) && (flag_z == (result == '0)));

  // R6: equal operands in a plain subtract never borrow
  assert_equal_sub_no_borrow_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_en && op == OP_SUB && opa == opb) |=> flag_c && flag_z);

endmodule

// File: tb/addsub_carry_unit_test.sv
`timescale 1ns/1ps
module addsub_carry_unit_test;

  localparam int W = 4;
  localparam int MOD = 1 << W;
  localparam int SMAX = (1 << (W - 1)) - 1;
  localparam int SMIN = -(1 << (W - 1));

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   op = 3'd0;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic         carry_in = 1'b0;
  logic         flag_en = 1'b0;
  logic [W-1:0] result;
  logic         flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // expected flag state
  logic en_n = 0, en_z = 0, en_c = 0, en_v = 0;

  always #4 clk = ~clk;

  addsub_carry_unit #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .op(op), .opa(opa), .opb(opb),
    .carry_in(carry_in), .flag_en(flag_en), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not complete, got %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sgn(input int u);
    return (u > SMAX) ? u - MOD : u;
  endfunction

  task automatic step(input int o, input int a, input int b, input int c, input int fe);
    @(negedge clk);
    op = o[2:0]; opa = a[W-1:0]; opb = b[W-1:0];
    carry_in = c[0]; flag_en = fe[0];
    @(posedge clk);
    @(negedge clk);
  endtask

  // one operation and a full comparison against integer arithmetic
  task automatic run_op(input int o, input int a, input int b, input int c, input int fe);
    int u, s, res, cy;
    string rq;
    u = 0; s = 0; cy = 0;
    case (o)
      0: begin u = a + b;           s = sgn(a) + sgn(b);           cy = (u >= MOD); rq = "R1"; end
      1: begin u = a - b;           s = sgn(a) - sgn(b);           cy = (u >= 0);   rq = "R2"; end
      2: begin u = b - a;           s = sgn(b) - sgn(a);           cy = (u >= 0);   rq = "R2"; end
      3: begin u = a + b + c;       s = sgn(a) + sgn(b) + c;       cy = (u >= MOD); rq = "R3"; end
      4: begin u = a - b - (1 - c); s = sgn(a) - sgn(b) - (1 - c); cy = (u >= 0);   rq = "R4"; end
      5: begin u = b - a - (1 - c); s = sgn(b) - sgn(a) - (1 - c); cy = (u >= 0);   rq = "R4"; end
      default: begin u = 0; s = 0; rq = "R9"; end
    endcase
    res = ((u % MOD) + MOD) % MOD;
    if (o <= 5 && fe != 0) begin
      en_n = (res >= (MOD / 2));
      en_z = (res == 0);
      en_c = cy[0];
      en_v = (s > SMAX) || (s < SMIN);
    end
    step(o, a, b, c, fe);
    check(rq, int'(result), res);
    check(fe != 0 && o <= 5 ? "R5" : (o > 5 ? "R9" : "R8"),
          int'({flag_n, flag_z}), int'({en_n, en_z}));
    check(fe != 0 && o <= 5 ? "R6" : (o > 5 ? "R9" : "R8"), int'(flag_c), int'(en_c));
    check(fe != 0 && o <= 5 ? "R7" : (o > 5 ? "R9" : "R8"), int'(flag_v), int'(en_v));
  endtask

  initial begin
    int idx;
    int lo, hi;
    // R10: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R10", int'(result), 0);
    check("R10", int'({flag_n, flag_z, flag_c, flag_v}), 0);

    // exhaustive sweep; flag_en alternates in a pattern that breaks parity with operands
    idx = 0;
    for (int o = 0; o < 8; o++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < MOD; a++)
          for (int b = 0; b < MOD; b++) begin
            run_op(o, a, b, c, ((idx % 3) != 2) ? 1 : 0);
            idx++;
          end

    // R11: two-word add 0x9F + 0x71 = 0x110
    step(0, 'hF, 'h1, 0, 1);
    lo = int'(result);
    step(3, 'h9, 'h7, int'(flag_c), 1);
    hi = int'(result);
    check("R11", hi * MOD + lo, (9 * MOD + 15 + 7 * MOD + 1) % (MOD * MOD));
    check("R11", int'(flag_c), 1);

    // R11: two-word subtract 0x30 - 0x01 = 0x2F
    step(1, 'h0, 'h1, 0, 1);
    lo = int'(result);
    step(4, 'h3, 'h0, int'(flag_c), 1);
    hi = int'(result);
    check("R11", hi * MOD + lo, 3 * MOD - 1);
    check("R11", int'(flag_c), 1);

    // R10: reset clears a nonzero state
    step(0, 'h8, 'h8, 0, 1);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R10", int'(result), 0);
    check("R10", int'({flag_n, flag_z, flag_c, flag_v}), 0);
    rst = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule